// File: doc/BRIEF.md
# Overlay Fast-Blank Output Level Mixer

This block forms the digital output level code of three colour channels in a display preamplifier datapath. Each cycle it picks one of four channel contents: scaled main-picture video, a solid overlay colour, half-contrast see-through video, or a blanked level. The choice comes from the fast-blank bit, the three overlay colour bits, the see-through enable and the blanking input. It then adds the common brightness offset, applies a per-channel drive gain, and places the result on a black pedestal that sits a fixed step above the DC output level.

All level codes come in as static setting inputs. The video samples and the control bits are sampled on the same edge, and the three output codes are registered, so every output follows its inputs by one clock. Drive gain is an 8-bit multiply with a divide by 256. It scales brightness and content but never the pedestal, so a white-balance setting holds for video, overlay and brightness alike.

Top module: `osd_mix_sel`

## Requirements
- R1: While `rst_n` is low all three output codes are 0.
- R2: Every output code is computed from the inputs sampled at the previous rising clock edge (one clock of latency).
- R3: With `blank_in` low and `fblank_in` low, channel n outputs `dc*16 + 24 + drv_n*(bright + vid_n*contrast/256)/256`, each division truncating. Channel n (n = 1..3) uses bits `[(n-1)*W +: W]` of every packed per-channel bus.
- R4: With `blank_in` low, `fblank_in` high and `seethru_en` low, channel n ignores its video and uses content `osd_lvl*16` when overlay bit `osd_bits[n-1]` is 1 and content 0 when it is 0. The content goes in place of the scaled video in the R3 formula.
- R5: With `blank_in` low, `fblank_in` high, `seethru_en` high and `osd_bits` = 3'b101 (channel 1 and channel 3 set, channel 2 clear), every channel uses content `vid_n*contrast/512`.
- R6: With `seethru_en` high and fast-blank high, any overlay pattern other than 3'b101 gives the solid overlay colours of R4.
- R7: With `seethru_en` low, the pattern 3'b101 gives solid overlay colours, not see-through video.
- R8: With `blank_in` high, every output is `dc*16`, whatever the fast-blank, brightness, overlay, video and drive inputs are.
- R9: Drive does not scale the pedestal: with `drv_n` = 0 and `blank_in` low, channel n outputs `dc*16 + 24` for any brightness and content.
- R10: When the sum exceeds 511, the output code saturates at 511.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank_in | input | 1 | Blanking input, highest priority |
| fblank_in | input | 1 | Fast-blank: selects overlay over video |
| seethru_en | input | 1 | Enables the see-through overlay pattern |
| osd_bits | input | 3 | Overlay colour bits, bit 0 is channel 1 |
| vid_in | input | 24 | Video samples, 8 bits per channel |
| bright | input | 8 | Brightness offset code |
| contrast | input | 8 | Contrast gain code (x/256) |
| osd_lvl | input | 4 | Overlay amplitude code (16 output units per step) |
| dc_lvl | input | 4 | DC output level code (16 output units per step) |
| drv_gain | input | 24 | Drive gain per channel, 8 bits each (x/256) |
| out_code | output | 27 | Output level codes, 9 bits per channel |

## Verification
The hardest case to reach is the see-through mode. It needs fast-blank high, the enable high, blanking low and exactly the 1-0-1 overlay pattern all at once. Its result must also be told apart from both the full-contrast video result and the overlay result. The stimulus therefore uses video and contrast values whose half- and full-contrast products differ, and an overlay level that gives yet another code. It then steps through every neighbouring pattern and the enable-off case with the same data, so a wrong decode shows up as a distinct value.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;
  typedef enum logic [1:0] {
    MD_VIDEO = 2'd0,
    MD_OSD   = 2'd1,
    MD_SEMI  = 2'd2,
    MD_BLANK = 2'd3
  } mix_mode_e;
endpackage

// File: rtl/osd_mode_dec.sv
module osd_mode_dec
  import osd_mix_pkg::*;
#(
  parameter int NCH = 3,
  parameter logic [NCH-1:0] SEMI_PAT = 3'b101
) (
  input  logic           blank_in,
  input  logic           fblank_in,
  input  logic           seethru_en,
  input  logic [NCH-1:0] osd_bits,
  output mix_mode_e      mode
);
  always_comb begin
    if (blank_in)                                   mode = MD_BLANK;
    else if (!fblank_in)                            mode = MD_VIDEO;
    else if (seethru_en && (osd_bits == SEMI_PAT))  mode = MD_SEMI;
    else                                            mode = MD_OSD;
  end
endmodule

// File: rtl/osd_chan_calc.sv
module osd_chan_calc
  import osd_mix_pkg::*;
#(
  parameter int VID_W   = 8,
  parameter int BRT_W   = 8,
  parameter int CON_W   = 8,
  parameter int OSD_W   = 4,
  parameter int DC_W    = 4,
  parameter int DRV_W   = 8,
  parameter int OUT_W   = 9,
  parameter int DC_STEP  = 16,
  parameter int OSD_STEP = 16,
  parameter int BLK_GAP  = 24
) (
  input  mix_mode_e         mode,
  input  logic              osd_bit,
  input  logic [VID_W-1:0]  vid,
  input  logic [BRT_W-1:0]  brt,
  input  logic [CON_W-1:0]  con,
  input  logic [OSD_W-1:0]  osd_lvl,
  input  logic [DC_W-1:0]   dc,
  input  logic [DRV_W-1:0]  drv,
  output logic [OUT_W-1:0]  code
);
  localparam int ACC_W = VID_W + CON_W + BRT_W + DRV_W + DC_W + 8;
  localparam logic [ACC_W-1:0] OUT_MAX = ACC_W'((1 << OUT_W) - 1);

  logic [ACC_W-1:0] vprod, content, dc_base, pedestal, scaled, total;

  always_comb begin
    vprod    = ACC_W'(vid) * ACC_W'(con);
    dc_base  = ACC_W'(dc) * ACC_W'(DC_STEP);
    pedestal = dc_base + ACC_W'(BLK_GAP);
    unique case (mode)
      MD_VIDEO: content = vprod >> CON_W;
      MD_SEMI:  content = vprod >> (CON_W + 1);
      MD_OSD:   content = osd_bit ? ACC_W'(osd_lvl) * ACC_W'(OSD_STEP) : '0;
      default:  content = '0;
    endcase
    scaled = (ACC_W'(drv) * (ACC_W'(brt) + content)) >> DRV_W;
    total  = (mode == MD_BLANK) ? dc_base : pedestal + scaled;
    code   = (total > OUT_MAX) ? OUT_MAX[OUT_W-1:0] : total[OUT_W-1:0];
  end
endmodule

// File: rtl/osd_mix_sel.sv
module osd_mix_sel
  import osd_mix_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int VID_W = 8,
  parameter int BRT_W = 8,
  parameter int CON_W = 8,
  parameter int OSD_W = 4,
  parameter int DC_W  = 4,
  parameter int DRV_W = 8,
  parameter int OUT_W = 9,
  parameter int DC_STEP  = 16,
  parameter int OSD_STEP = 16,
  parameter int BLK_GAP  = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 blank_in,
  input  logic                 fblank_in,
  input  logic                 seethru_en,
  input  logic [NCH-1:0]       osd_bits,
  input  logic [NCH*VID_W-1:0] vid_in,
  input  logic [BRT_W-1:0]     bright,
  input  logic [CON_W-1:0]     contrast,
  input  logic [OSD_W-1:0]     osd_lvl,
  input  logic [DC_W-1:0]      dc_lvl,
  input  logic [NCH*DRV_W-1:0] drv_gain,
  output logic [NCH*OUT_W-1:0] out_code
);
  localparam logic [NCH-1:0] SEMI_PAT = NCH'(3'b101);

  mix_mode_e            mode;
  logic [NCH*OUT_W-1:0] code_nxt;

  osd_mode_dec #(.NCH(NCH), .SEMI_PAT(SEMI_PAT)) u_dec (
    .blank_in   (blank_in),
    .fblank_in  (fblank_in),
    .seethru_en (seethru_en),
    .osd_bits   (osd_bits),
    .mode       (mode)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    osd_chan_calc #(
      .VID_W(VID_W), .BRT_W(BRT_W), .CON_W(CON_W), .OSD_W(OSD_W),
      .DC_W(DC_W), .DRV_W(DRV_W), .OUT_W(OUT_W),
      .DC_STEP(DC_STEP), .OSD_STEP(OSD_STEP), .BLK_GAP(BLK_GAP)
    ) u_ch (
      .mode    (mode),
      .osd_bit (osd_bits[n]),
      .vid     (vid_in[n*VID_W +: VID_W]),
      .brt     (bright),
      .con     (contrast),
      .osd_lvl (osd_lvl),
      .dc      (dc_lvl),
      .drv     (drv_gain[n*DRV_W +: DRV_W]),
      .code    (code_nxt[n*OUT_W +: OUT_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_code <= '0;
    else        out_code <= code_nxt;
  end
endmodule

// File: rtl/osd_mix_chk.sv
module osd_mix_chk #(
  parameter int NCH = 3, parameter int BRT_W = 8, parameter int CON_W = 8,
  parameter int DC_W = 4, parameter int DRV_W = 8, parameter int OUT_W = 9,
  parameter int DC_STEP = 16, parameter int BLK_GAP = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 blank_in,
  input logic                 fblank_in,
  input logic [BRT_W-1:0]     bright,
  input logic [CON_W-1:0]     contrast,
  input logic [DC_W-1:0]      dc_lvl,
  input logic [NCH*DRV_W-1:0] drv_gain,
  input logic [NCH*OUT_W-1:0] out_code
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> out_code == '0);

  // R8
  blank_dc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(blank_in)) |->
      (out_code[OUT_W-1:0] == OUT_W'($past(dc_lvl) * DC_STEP) &&
       out_code[NCH*OUT_W-1 -: OUT_W] == OUT_W'($past(dc_lvl) * DC_STEP)));

  // R3
  video_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(blank_in) && !$past(fblank_in) &&
     $past(bright) == '0 && $past(contrast) == '0) |->
      out_code[OUT_W-1:0] == OUT_W'($past(dc_lvl) * DC_STEP + BLK_GAP));

  // R9
  drive_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(blank_in) && $past(drv_gain[DRV_W-1:0]) == '0) |->
      out_code[OUT_W-1:0] == OUT_W'($past(dc_lvl) * DC_STEP + BLK_GAP));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(blank_in) && blank_in && $stable(dc_lvl)) |=>
      $stable(out_code));
endmodule

bind osd_mix_sel osd_mix_chk #(
  .NCH(NCH), .BRT_W(BRT_W), .CON_W(CON_W), .DC_W(DC_W), .DRV_W(DRV_W),
  .OUT_W(OUT_W), .DC_STEP(DC_STEP), .BLK_GAP(BLK_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .blank_in(blank_in), .fblank_in(fblank_in),
  .bright(bright), .contrast(contrast), .dc_lvl(dc_lvl),
  .drv_gain(drv_gain), .out_code(out_code)
);

// File: tb/sim_osd_mix_sel.sv
module sim_osd_mix_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        blank_in, fblank_in, seethru_en;
  logic [2:0]  osd_bits;
  logic [23:0] vid_in, drv_gain;
  logic [7:0]  bright, contrast;
  logic [3:0]  osd_lvl, dc_lvl;
  logic [26:0] out_code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  osd_mix_sel u0 (
    .clk(clk), .rst_n(rst_n), .blank_in(blank_in), .fblank_in(fblank_in),
    .seethru_en(seethru_en), .osd_bits(osd_bits), .vid_in(vid_in),
    .bright(bright), .contrast(contrast), .osd_lvl(osd_lvl), .dc_lvl(dc_lvl),
    .drv_gain(drv_gain), .out_code(out_code)
  );

  function automatic int expect_code(int ch);
    int vid, drv, content, total;
    vid = int'(vid_in[ch*8 +: 8]);
    drv = int'(drv_gain[ch*8 +: 8]);
    if (blank_in) return int'(dc_lvl) * 16;
    if (!fblank_in)                           content = vid * int'(contrast) / 256;
    else if (seethru_en && osd_bits == 3'b101) content = vid * int'(contrast) / 512;
    else content = osd_bits[ch] ? int'(osd_lvl) * 16 : 0;
    total = int'(dc_lvl) * 16 + 24 + drv * (int'(bright) + content) / 256;
    return (total > 511) ? 511 : total;
  endfunction

  task automatic check(string req, int ch, int exp);
    int act;
    act = int'(out_code[ch*9 +: 9]);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ch%0d: actual %0d expected %0d", req, ch + 1, act, exp);
    end
  endtask

  // drive at negedge, register at posedge, sample 1 ns later
  task automatic apply_and_check(string req);
    int e0, e1, e2;
    e0 = expect_code(0); e1 = expect_code(1); e2 = expect_code(2);
    @(posedge clk); #1;
    check(req, 0, e0); check(req, 1, e1); check(req, 2, e2);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    blank_in = 0; fblank_in = 0; seethru_en = 0; osd_bits = 3'b111;
    vid_in = 24'hFFFFFF; drv_gain = 24'hFFFFFF; bright = 8'd200;
    contrast = 8'd200; osd_lvl = 4'd9; dc_lvl = 4'd7;
    repeat (3) @(posedge clk);
    #1;
    for (int c = 0; c < 3; c++) check("R1", c, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_video;
    fblank_in = 0; blank_in = 0; osd_bits = 3'b010;
    vid_in = {8'd40, 8'd128, 8'd255}; contrast = 8'd128; bright = 8'd10;
    drv_gain = {8'd255, 8'd128, 8'd64}; dc_lvl = 4'd2;
    apply_and_check("R3");
    vid_in = {8'd0, 8'd77, 8'd200}; contrast = 8'd255; bright = 8'd0;
    drv_gain = {8'd200, 8'd200, 8'd200}; dc_lvl = 4'd0;
    apply_and_check("R3");
  endtask

  task automatic t_latency;
    int e0;
    fblank_in = 0; blank_in = 0; vid_in = {8'd10, 8'd20, 8'd240};
    contrast = 8'd255; bright = 8'd5; drv_gain = 24'hFFFFFF; dc_lvl = 4'd1;
    e0 = expect_code(0);
    @(posedge clk); #1;
    vid_in = {8'd10, 8'd20, 8'd0};
    check("R2", 0, e0);
    @(negedge clk);
    apply_and_check("R2");
  endtask

  task automatic t_osd;
    fblank_in = 1; blank_in = 0; seethru_en = 0; osd_lvl = 4'd11;
    vid_in = {8'd255, 8'd255, 8'd255}; contrast = 8'd255; bright = 8'd20;
    drv_gain = {8'd100, 8'd180, 8'd255}; dc_lvl = 4'd3;
    for (int p = 0; p < 8; p++) begin
      osd_bits = 3'(p);
      apply_and_check(p == 5 ? "R7" : "R4");
    end
  endtask

  task automatic t_semi;
    fblank_in = 1; blank_in = 0; seethru_en = 1; osd_lvl = 4'd6;
    vid_in = {8'd90, 8'd180, 8'd250}; contrast = 8'd200; bright = 8'd8;
    drv_gain = {8'd255, 8'd160, 8'd220}; dc_lvl = 4'd4;
    osd_bits = 3'b101;
    apply_and_check("R5");
    for (int p = 0; p < 8; p++) begin
      if (p == 5) continue;
      osd_bits = 3'(p);
      apply_and_check("R6");
    end
  endtask

  task automatic t_blank;
    blank_in = 1; fblank_in = 1; seethru_en = 1; osd_bits = 3'b101;
    bright = 8'd255; dc_lvl = 4'd9; drv_gain = 24'hFFFFFF;
    apply_and_check("R8");
    fblank_in = 0; dc_lvl = 4'd15; bright = 8'd0;
    apply_and_check("R8");
    blank_in = 0;
  endtask

  task automatic t_drive_zero;
    fblank_in = 0; blank_in = 0; bright = 8'd255; contrast = 8'd255;
    vid_in = 24'hFFFFFF; drv_gain = {8'd0, 8'd0, 8'd0}; dc_lvl = 4'd5;
    apply_and_check("R9");
    fblank_in = 1; seethru_en = 0; osd_bits = 3'b111; osd_lvl = 4'd15;
    apply_and_check("R9");
  endtask

  task automatic t_sat;
    fblank_in = 0; blank_in = 0; bright = 8'd255; contrast = 8'd255;
    vid_in = 24'hFFFFFF; drv_gain = 24'hFFFFFF; dc_lvl = 4'd15;
    apply_and_check("R10");
    fblank_in = 1; seethru_en = 0; osd_bits = 3'b111; osd_lvl = 4'd15;
    apply_and_check("R10");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_video();
        t_latency();
        t_osd();
        t_semi();
        t_blank();
        t_drive_zero();
        t_sat();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule